// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master that a processor drives through a small word-addressed register file. Software selects the clock polarity and phase, the bit order, the word length, an internal loopback path, a data-alignment variant and the serial clock rate through a single mode register. It then writes a word into the transmit register. The engine shifts that word out on `mosi` while it samples `miso`, stores the received word in the receive register and raises a receive event. An interrupt line combines the pending events with a mask.

A one-word holding register sits in front of the shift engine. Software can therefore queue the next word while the current word is still on the wire, and the engine chains the two words without a gap of more than one clock. Mode fields are changed in two steps: first a write with the enable bit clear, then the same value again with enable set. Clearing enable stops the engine at once.

Register map (word address on `reg_addr`): 0 mode, 1 event, 2 mask, 3 transmit (reads as zero), 4 receive. Any other address reads as zero.

Top module: `spi_regmaster`

## Requirements
- R1: After reset, every register reads zero, `irq` is low, `sck` is low and `mosi` is low.
- R2: The mode register stores bits 30:16 and bit 14 of a write and reads them back, with all other bits reading zero. The control bits are: 30 loopback, 29 clock idles high, 28 data changes on the leading edge, 27 extra divide-by-16, 26 MSB first, 25 master select (stored only), 24 enable. Bits 23:20 hold the length field, bits 19:16 hold the prescale value PM, and bit 14 selects alternate alignment.
- R3: A length field L from 3 to 15 gives words of L+1 bits, and L=0 gives 32-bit words. In normal alignment, transmit and receive words are right-aligned in bits [len-1:0]. Transmit bits above the word are ignored, and receive bits above the word read zero.
- R4: Each half period of `sck` lasts 2×(PM+1) clocks, or 32×(PM+1) clocks when the divide-by-16 bit is set.
- R5: While idle, `sck` rests at the idle level that bit 29 selects. With bit 28 clear, the first bit is presented before the first edge, and both sides sample on leading edges. With bit 28 set, data is sampled on trailing edges.
- R6: With bit 26 set, the word goes out and comes in most significant bit first. With bit 26 clear, it goes out and comes in least significant bit first.
- R7: With loopback set, the received word equals the transmitted word whatever `miso` does.
- R8: Alternate alignment applies with MSB first. Words of 8 bits or fewer are taken from transmit bits 31:24 and returned at receive bits 23:16. Words of 9 to 16 bits use bits 31:16 in both registers. With LSB first, transmit data is right-aligned, and received words of 8 bits or fewer appear at bits 15:8.
- R9: Event bit 9 (receive not empty) sets at the end of every word. Event bit 8 (transmit not full) sets when the holding register hands its word to the shifter. A transmit write clears bit 8. Writing a 1 to an event bit clears it. A set in the same cycle wins over a clear.
- R10: `irq` is high exactly when an event bit is set and the mask bit at the same position (9 or 8) is also set.
- R11: A word written while a transfer runs is held. It starts as soon as the current word ends, and both words are received in order.
- R12: While enable is clear, transmit writes are ignored. Clearing enable during a transfer aborts it and drops any held word, and no event is raised. Setting enable again starts no transfer by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench targets the data-phase corners. A slave model in the bench answers in polarity/phase combinations 0 and 3. If the sample and shift edges were swapped, the slave would see a word shifted by one bit. If the trailing-edge phase ended one half period too early, the last received bit would be lost. Length 32 (field 0) and length 4 are both exercised: an engine that decodes field 0 as one bit, or that leaks upper transmit bits, returns a wrong word. The bench runs all three alternate-alignment cases, where a wrong shift puts the byte in the wrong lane. It measures the serial clock half period in both prescaler ranges, so an off-by-one in the divider shows up as a wrong count. It checks back-to-back words, which a design that overwrote the shifter would corrupt. It also aborts a transfer by clearing enable, and a design that let the transfer finish would raise a stray receive event.

// File: rtl/spi_regmaster.sv
module spi_regmaster #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq,
  output logic          sck,
  output logic          mosi,
  input  logic          miso
);
  localparam int          CW        = 10;
  localparam int          EW        = 7;
  localparam logic [DW-1:0] MODE_KEEP = 32'h7FFF_4000;
  localparam logic [AW-1:0] A_MODE  = 3'd0;
  localparam logic [AW-1:0] A_EVT   = 3'd1;
  localparam logic [AW-1:0] A_MASK  = 3'd2;
  localparam logic [AW-1:0] A_TX    = 3'd3;
  localparam logic [AW-1:0] A_RX    = 3'd4;

  logic [DW-1:0] mode_q, hold_q, sh_q, rx_q;
  logic [1:0]    mask_q;
  logic          ev_ne_q, ev_nf_q, hold_full, busy_q, sck_q, rxbit_q;
  logic [EW-1:0] edge_q;
  logic [CW-1:0] cnt_q;

  wire       en    = mode_q[24];
  wire       cpol  = mode_q[29];
  wire       cpha  = mode_q[28];
  wire       div16 = mode_q[27];
  wire       msbf  = mode_q[26];
  wire       loopb = mode_q[30];
  wire       alt   = mode_q[14];
  wire [3:0] lenf  = mode_q[23:20];
  wire [3:0] pm    = mode_q[19:16];

  logic [5:0]    nbits;
  logic [EW-1:0] two_n;
  logic [CW-1:0] half;
  logic [DW-1:0] lenmask, txw, load_w, nsh, word_r;
  logic [4:0]    txs, rxs;
  logic          tick, sample_e, shift_e, toggle_e, last_e, out_bit, in_bit;

  assign nbits   = (lenf == 4'd0) ? 6'd32 : {2'b00, lenf} + 6'd1;
  assign two_n   = {nbits, 1'b0};
  assign half    = div16 ? (({6'd0, pm} + 10'd1) << 5) : (({6'd0, pm} + 10'd1) << 1);
  assign lenmask = (nbits == 6'd32) ? '1 : ((32'd1 << nbits) - 32'd1);

  always_comb begin
    txs = 5'd0;
    rxs = 5'd0;
    if (alt && msbf && nbits <= 6'd8)       txs = 5'd24;
    else if (alt && msbf && nbits <= 6'd16) txs = 5'd16;
    if (alt && msbf && nbits <= 6'd16)      rxs = 5'd16;
    else if (alt && !msbf && nbits <= 6'd8) rxs = 5'd8;
  end

  assign txw    = (hold_q >> txs) & lenmask;
  assign load_w = msbf ? (txw << (6'd32 - nbits)) : txw;

  assign out_bit  = msbf ? sh_q[31] : sh_q[0];
  assign in_bit   = loopb ? out_bit : miso;
  assign tick     = busy_q && (cnt_q == half - 10'd1);
  assign toggle_e = edge_q < two_n;
  assign sample_e = toggle_e && (edge_q[0] == cpha);
  assign shift_e  = !sample_e && !(cpha && edge_q == '0);
  assign last_e   = cpha ? (edge_q == two_n) : (edge_q == two_n - 7'd1);
  assign nsh      = msbf ? {sh_q[30:0], rxbit_q} : {rxbit_q, sh_q[31:1]};
  assign word_r   = msbf ? (nsh & lenmask) : ((nsh >> (6'd32 - nbits)) & lenmask);

  assign sck  = sck_q;
  assign mosi = busy_q & out_bit;
  assign irq  = |({ev_ne_q, ev_nf_q} & mask_q);

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_EVT:   reg_rdata = {22'd0, ev_ne_q, ev_nf_q, 8'd0};
      A_MASK:  reg_rdata = {22'd0, mask_q, 8'd0};
      A_RX:    reg_rdata = rx_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      mask_q    <= '0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      sh_q      <= '0;
      rx_q      <= '0;
      rxbit_q   <= 1'b0;
      ev_ne_q   <= 1'b0;
      ev_nf_q   <= 1'b0;
      busy_q    <= 1'b0;
      sck_q     <= 1'b0;
      edge_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (reg_we && reg_addr == A_MODE) mode_q <= reg_wdata & MODE_KEEP;
      if (reg_we && reg_addr == A_MASK) mask_q <= reg_wdata[9:8];
      if (reg_we && reg_addr == A_EVT) begin
        if (reg_wdata[9]) ev_ne_q <= 1'b0;
        if (reg_wdata[8]) ev_nf_q <= 1'b0;
      end

      if (!en) begin
        busy_q    <= 1'b0;
        hold_full <= 1'b0;
        sck_q     <= cpol;
        edge_q    <= '0;
        cnt_q     <= '0;
      end else if (!busy_q) begin
        if (hold_full) begin
          sh_q      <= load_w;
          busy_q    <= 1'b1;
          hold_full <= 1'b0;
          ev_nf_q   <= 1'b1;
          edge_q    <= '0;
          cnt_q     <= '0;
        end
      end else begin
        cnt_q <= tick ? '0 : cnt_q + 10'd1;
        if (tick) begin
          edge_q <= edge_q + 7'd1;
          if (toggle_e) sck_q <= ~sck_q;
          if (sample_e) rxbit_q <= in_bit;
          if (shift_e)  sh_q <= nsh;
          if (last_e) begin
            rx_q    <= word_r << rxs;
            ev_ne_q <= 1'b1;
            edge_q  <= '0;
            if (hold_full) begin
              sh_q      <= load_w;
              hold_full <= 1'b0;
              ev_nf_q   <= 1'b1;
            end else begin
              busy_q <= 1'b0;
            end
          end
        end
      end

      if (reg_we && reg_addr == A_TX && en) begin
        hold_q    <= reg_wdata;
        hold_full <= 1'b1;
        ev_nf_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       irq,
  input logic       en,
  input logic       cpol,
  input logic       busy,
  input logic       ev_ne,
  input logic [1:0] msk
);
  // R5: idle level follows polarity while disabled
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en) && $stable(cpol)) |-> (sck == cpol));
  // R12: disabling stops the engine
  a_r12_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
  // R12: no clock activity without a running word
  a_r12_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(busy)) |-> $stable(sck));
  // R9: receive event only ends a running word
  a_r9_ne_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_ne) |-> $past(busy));
  // R10: fully masked events never interrupt
  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (msk == 2'b00) |-> !irq);
endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .irq(irq), .en(en), .cpol(cpol),
  .busy(busy_q), .ev_ne(ev_ne_q), .msk(mask_q)
);

// File: tb/spi_regmaster_tb.sv
module spi_regmaster_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi;
  logic        miso_r = 1'b0;
  int checks = 0;
  int errors = 0;
  logic b_cpol = 1'b0, b_cpha = 1'b0;
  logic sck_d = 1'b0;
  logic [31:0] s_tx = '0, s_rx = '0;

  always #2 clk = ~clk;

  spi_regmaster u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso_r)
  );

  always @(negedge clk) begin
    sck_d <= sck;
    if (rst_n && sck != sck_d) begin
      if ((sck != b_cpol) == !b_cpha) s_rx <= {s_rx[30:0], mosi};
      else begin
        miso_r <= s_tx[31];
        s_tx   <= s_tx << 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] mw(input bit loopb, input bit cpol, input bit cpha,
      input bit d16, input bit msbf, input bit alt, input int n, input int pm, input bit en);
    logic [3:0] lf = (n == 32) ? 4'd0 : 4'(n - 1);
    return {1'b0, loopb, cpol, cpha, d16, msbf, 1'b1, en, lf, 4'(pm), 1'b0, alt, 14'd0};
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] v, input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = v[n-1-i];
    return r;
  endfunction

  task automatic cfg(input logic [31:0] m);
    b_cpol = m[29]; b_cpha = m[28];
    wr(3'd0, m & ~32'h0100_0000);
    wr(3'd0, m);
    wr(3'd1, 32'h300);
  endtask

  task automatic wait_ne(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd1, v);
      if (v[9]) begin ok = 1; break; end
    end
  endtask

  task automatic slave_load(input logic [31:0] v, input int n);
    logic [31:0] al = v << (32 - n);
    s_rx = '0;
    if (b_cpha) begin miso_r = 1'b0; s_tx = al; end
    else begin miso_r = al[31]; s_tx = al << 1; end
  endtask

  task automatic xfer(input string req, input logic [31:0] tx, input logic [31:0] exp);
    logic [31:0] v; bit ok;
    wr(3'd1, 32'h300);
    wr(3'd3, tx);
    wait_ne(ok);
    rd(3'd4, v);
    chk(req, ok ? v : 32'hxxxx_dead, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin rd(3'(a), v); chk("R1 regs", v, 0); end
    chk("R1 pins", {29'd0, irq, sck, mosi}, 0);
  endtask

  task automatic t_mode_rb;
    logic [31:0] v;
    wr(3'd0, 32'hFEFF_FFFF);
    rd(3'd0, v);
    chk("R2 readback", v, 32'h7EFF_4000);
    wr(3'd0, 0);
  endtask

  task automatic t_loop;
    cfg(mw(1, 0, 0, 0, 1, 0, 8, 0, 1));
    xfer("R7 loop8", 32'h0000_00A5, 32'hA5);
    cfg(mw(1, 0, 0, 0, 1, 0, 32, 0, 1));
    xfer("R3 len32", 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    cfg(mw(1, 1, 1, 0, 1, 0, 4, 0, 1));
    xfer("R3 len4", 32'hFFFF_FFF6, 32'h6);
  endtask

  task automatic t_mode0;
    cfg(mw(0, 0, 0, 0, 1, 0, 8, 1, 1));
    slave_load(32'h96, 8);
    xfer("R5 mode0 rx", 32'h3C, 32'h96);
    chk("R5 mode0 slave", s_rx & 32'hFF, 32'h3C);
  endtask

  task automatic t_mode3_lsb;
    cfg(mw(0, 1, 1, 0, 0, 0, 16, 0, 1));
    slave_load(32'hBEEF, 16);
    xfer("R6 lsb rx", 32'h1234, rev(32'hBEEF, 16));
    chk("R6 lsb slave", s_rx & 32'hFFFF, rev(32'h1234, 16));
    chk("R5 idle high", {31'd0, sck}, 1);
  endtask

  task automatic t_alt;
    cfg(mw(1, 0, 0, 0, 1, 1, 8, 0, 1));
    xfer("R8 alt msb8", 32'h5A00_0000, 32'h005A_0000);
    cfg(mw(1, 0, 0, 0, 1, 1, 16, 0, 1));
    xfer("R8 alt msb16", 32'hC3A5_0000, 32'hC3A5_0000);
    cfg(mw(1, 0, 0, 0, 0, 1, 8, 0, 1));
    xfer("R8 alt lsb8", 32'h0000_005A, 32'h0000_5A00);
  endtask

  task automatic t_rate(input bit d16, input int pm, input int exp_half);
    int t[3]; int k = 0; int cyc = 0; logic last;
    bit ok;
    cfg(mw(1, 0, 0, d16, 1, 0, 8, pm, 1));
    wr(3'd3, 32'h55);
    last = sck;
    while (k < 3 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (sck != last) begin t[k] = cyc; k++; last = sck; end
    end
    chk("R4 half period", 32'(t[2] - t[1]), 32'(exp_half));
    wait_ne(ok);
  endtask

  task automatic t_b2b;
    logic [31:0] v; bit ok;
    cfg(mw(1, 0, 0, 0, 1, 0, 8, 0, 1));
    wr(3'd3, 32'h11);
    wr(3'd1, 32'h300);
    wr(3'd3, 32'h22);
    rd(3'd1, v);
    chk("R9 nf cleared by write", v & 32'h300, 0);
    wait_ne(ok);
    rd(3'd4, v);
    chk("R11 first word", v, 32'h11);
    rd(3'd1, v);
    chk("R11 nf on handover", v & 32'h100, 32'h100);
    wr(3'd1, 32'h100);
    rd(3'd1, v);
    chk("R9 w1c keeps ne", v & 32'h300, 32'h200);
    wr(3'd1, 32'h200);
    wait_ne(ok);
    rd(3'd4, v);
    chk("R11 second word", v, 32'h22);
  endtask

  task automatic t_irq;
    wr(3'd2, 32'h200);
    cfg(mw(1, 0, 0, 0, 1, 0, 8, 0, 1));
    xfer("R10 xfer", 32'h0F, 32'h0F);
    @(negedge clk);
    chk("R10 irq ne", {31'd0, irq}, 1);
    wr(3'd2, 0);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wr(3'd1, 32'h300);
    wr(3'd2, 32'h300);
    chk("R10 irq cleared", {31'd0, irq}, 0);
    wr(3'd2, 0);
  endtask

  task automatic t_abort;
    logic [31:0] v; logic m;
    cfg(mw(1, 1, 0, 0, 1, 0, 16, 3, 1));
    wr(3'd3, 32'h1234);
    repeat (20) @(negedge clk);
    wr(3'd0, mw(1, 1, 0, 0, 1, 0, 16, 3, 0));
    chk("R12 sck idle after abort", {31'd0, sck}, 1);
    wr(3'd3, 32'h4321);
    repeat (400) @(negedge clk);
    rd(3'd1, v);
    chk("R12 no event on abort", v & 32'h200, 0);
    wr(3'd0, mw(1, 1, 0, 0, 1, 0, 16, 3, 1));
    m = sck;
    repeat (400) @(negedge clk);
    rd(3'd1, v);
    chk("R12 no restart", {v[9], sck}, {1'b0, m});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog R1-all actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_rb();
    t_loop();
    t_mode0();
    t_mode3_lsb();
    t_alt();
    t_rate(0, 2, 6);
    t_rate(1, 1, 64);
    t_b2b();
    t_irq();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule